// File: doc/BRIEF.md
# Digital Optical-Black Clamp Loop

This block sits behind the ADC of an image sensor front end and holds the black level of every line at a digital target. While the clamp window strobe is active it collects the ADC codes of the shielded optical-black pixels: the first sixteen codes of the window are summed and shifted down to form the black level of that line. At the line-end strobe the measured level, either the level of that single line or the mean of the last four line levels, is compared with a target set by a 5-bit register field. A signed offset word is then moved one step in the direction that reduces the error. The offset word goes back to the analog front end, which applies it ahead of the ADC.

A settled flag tells the rest of the chip that the loop has converged: it rises after four consecutive in-band updates and drops on the first update that is out of band. A polarity input lets the strobes be used either active high or active low. An active-low soft reset returns all loop state to its start values without touching the hard reset.

Top module: `ob_clamp_loop`

## Requirements
- R1: The target level in LSBs is twice the 5-bit `clamp_set` value plus 14; the register's start value 9 gives a target of 32, and a setting of 0 gives 14.
- R2: Only the first 16 samples of a clamp window are summed, and the line level is that sum shifted right by 4. Samples past the sixteenth are ignored. A line whose window gave fewer than 16 samples causes no offset or settle update and does not count as a line for four-line averaging.
- R3: With `avg4_en` = 0, every qualifying line end performs one update using that line's level.
- R4: With `avg4_en` = 1, an update happens only at every fourth qualifying line end, counted from reset, using the sum of the last four line levels shifted right by 2.
- R5: At an update the offset word decreases by 1 when the level exceeds target + 1 and increases by 1 when the level is below target − 1. It is unchanged when the level lies within ±1 of the target, and it never changes between updates.
- R6: The offset word saturates at its signed limits (−32 and +31 for the default 6-bit width) instead of wrapping.
- R7: `settled` is 1 after four consecutive in-band updates, not after three. It returns to 0 at the first out-of-band update.
- R8: While `soft_rst_n` = 0, the offset word, the settle count, the sample accumulator, the line counter and the four-line buffer are cleared synchronously. 1 means normal operation.
- R9: With `strobe_pol` = 1 the window and line-end strobes are active high. With `strobe_pol` = 0 both are active low.
- R10: A line end is the first cycle of an active line-end strobe, so a strobe held active for several cycles makes one update. A window sample taken in a line-end cycle is discarded.
- R11: After hard reset the offset word is 0 and `settled` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_n | input | 1 | Synchronous soft reset bit, 0 = reset |
| strobe_pol | input | 1 | Strobe polarity, 1 = active high, 0 = active low |
| ob_win_in | input | 1 | Optical-black clamp window strobe |
| line_end_in | input | 1 | Line-end strobe |
| adc_code | input | DATA_W (10) | ADC output code |
| clamp_set | input | 5 | Clamp target setting |
| avg4_en | input | 1 | 0 = per-line detection, 1 = four-line averaged detection |
| ofs_word | output | OFS_W (6) | Signed offset correction word |
| settled | output | 1 | Loop settled flag |

## Verification
A window sample enters the accumulator at the rising edge where the strobe is seen. The offset word and `settled` take their new values at the same rising edge where the line-end strobe is first seen active, with no further pipeline stage. The bench drives every input on the falling edge and reads the outputs on a later falling edge, two cycles after the line-end pulse, so each check sees a settled result. In four-line mode the bench checks the offset after each of the three non-updating lines as well as after the fourth, and the values chosen there tell a four-line mean apart from the last line's level alone.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;
    localparam int CLAMP_W    = 5;
    localparam int CLAMP_BASE = 14;

    typedef enum logic [1:0] {
        CMP_IN   = 2'd0,
        CMP_LOW  = 2'd1,
        CMP_HIGH = 2'd2
    } cmp_e;
endpackage

// File: rtl/ob_strobe_cond.sv
module ob_strobe_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic pol,
    input  logic win_raw,
    input  logic le_raw,
    output logic win,
    output logic le_evt
);
    typedef struct packed {
        logic le_prev;
    } st_t;

    st_t  st_d, st_q;
    logic le_lvl;

    always_comb begin
        win       = pol ? win_raw : ~win_raw;
        le_lvl    = pol ? le_raw : ~le_raw;
        le_evt    = le_lvl & ~st_q.le_prev & ~srst;
        st_d      = st_q;
        st_d.le_prev = le_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: one event per strobe assertion
    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        le_evt |=> !le_evt);
endmodule

// File: rtl/ob_line_accum.sv
module ob_line_accum #(
    parameter int DATA_W   = 10,
    parameter int SMP_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              win,
    input  logic              le_evt,
    input  logic [DATA_W-1:0] code,
    output logic              line_valid,
    output logic [DATA_W-1:0] line_avg
);
    localparam int ACC_W = DATA_W + SMP_LOG2;
    localparam int CNT_W = SMP_LOG2 + 1;
    localparam logic [CNT_W-1:0] N_SMP = CNT_W'(1 << SMP_LOG2);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        line_valid = le_evt && (st_q.cnt == N_SMP);
        line_avg   = st_q.acc[ACC_W-1:SMP_LOG2];
        if (srst || le_evt) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (win && (st_q.cnt < N_SMP)) begin
            st_d.acc = st_q.acc + ACC_W'(code);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: sample count never passes the window size
    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= N_SMP);
    // R10: a line end restarts collection
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        le_evt |=> (st_q.cnt == '0));
endmodule

// File: rtl/ob_avg4.sv
module ob_avg4 #(
    parameter int DATA_W     = 10,
    parameter int DEPTH_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              avg4_en,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_avg,
    output logic              det_valid,
    output logic [DATA_W-1:0] det_level
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int SUM_W = DATA_W + DEPTH_LOG2;
    localparam logic [DEPTH_LOG2-1:0] LAST = DEPTH_LOG2'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] taps;
        logic [DEPTH_LOG2-1:0]        wr;
        logic [SUM_W-1:0]             sum;
    } st_t;

    st_t              st_d, st_q;
    logic [SUM_W-1:0] sum_new;

    always_comb begin
        st_d    = st_q;
        sum_new = st_q.sum - SUM_W'(st_q.taps[st_q.wr]) + SUM_W'(line_avg);
        det_valid = line_valid && (!avg4_en || (st_q.wr == LAST));
        det_level = avg4_en ? sum_new[SUM_W-1:DEPTH_LOG2] : line_avg;
        if (srst) begin
            st_d = '0;
        end else if (line_valid) begin
            st_d.taps[st_q.wr] = line_avg;
            st_d.wr            = st_q.wr + 1'b1;
            st_d.sum           = sum_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: in averaged mode no detection comes from a line that is not qualifying
    p_det_needs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |-> !det_valid);
endmodule

// File: rtl/ob_offset_ctrl.sv
module ob_offset_ctrl
    import ob_clamp_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int OFS_W    = 6,
    parameter int SETTLE_N = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    srst,
    input  logic                    det_valid,
    input  logic [DATA_W-1:0]       det_level,
    input  logic [CLAMP_W-1:0]      clamp_set,
    output logic signed [OFS_W-1:0] ofs,
    output logic                    settled
);
    localparam int CMP_W = DATA_W + 2;
    localparam int SC_W  = $clog2(SETTLE_N + 1);
    localparam logic [SC_W-1:0] SC_FULL = SC_W'(SETTLE_N);
    localparam logic signed [OFS_W-1:0] OFS_MAX = {1'b0, {(OFS_W-1){1'b1}}};
    localparam logic signed [OFS_W-1:0] OFS_MIN = {1'b1, {(OFS_W-1){1'b0}}};

    typedef struct packed {
        logic signed [OFS_W-1:0] ofs;
        logic [SC_W-1:0]         scnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CMP_W-1:0] tgt, lvl;
    cmp_e             cmp;

    always_comb begin
        tgt = (CMP_W'(clamp_set) << 1) + CMP_W'(CLAMP_BASE);
        lvl = CMP_W'(det_level);
        if (lvl > tgt + CMP_W'(1))      cmp = CMP_HIGH;
        else if (lvl + CMP_W'(1) < tgt) cmp = CMP_LOW;
        else                            cmp = CMP_IN;

        st_d = st_q;
        if (srst) begin
            st_d = '0;
        end else if (det_valid) begin
            unique case (cmp)
                CMP_HIGH: begin
                    st_d.scnt = '0;
                    if (st_q.ofs != OFS_MIN) st_d.ofs = st_q.ofs - 1'b1;
                end
                CMP_LOW: begin
                    st_d.scnt = '0;
                    if (st_q.ofs != OFS_MAX) st_d.ofs = st_q.ofs + 1'b1;
                end
                default: begin
                    if (st_q.scnt != SC_FULL) st_d.scnt = st_q.scnt + 1'b1;
                end
            endcase
        end
        ofs     = st_q.ofs;
        settled = (st_q.scnt == SC_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: offset only moves on an update
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_valid && !srst) |=> $stable(ofs));
    // R5: offset moves by at most one step
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> (ofs == $past(ofs)) || (ofs == $past(ofs) + 1'b1)
                  || (ofs == $past(ofs) - 1'b1));
    // R6: no wrap at the top limit
    p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_MAX && !srst) |=> ofs != OFS_MIN);
    // R6: no wrap at the bottom limit
    p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_MIN && !srst) |=> ofs != OFS_MAX);
    // R7: an out-of-band update clears the flag
    p_settle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && cmp != CMP_IN && !srst) |=> !settled);
    // R8: soft reset clears the loop state
    p_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ofs == '0) && !settled);
endmodule

// File: rtl/ob_clamp_loop.sv
module ob_clamp_loop
    import ob_clamp_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int OFS_W      = 6,
    parameter int SMP_LOG2   = 4,
    parameter int DEPTH_LOG2 = 2,
    parameter int SETTLE_N   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst_n,
    input  logic                    strobe_pol,
    input  logic                    ob_win_in,
    input  logic                    line_end_in,
    input  logic [DATA_W-1:0]       adc_code,
    input  logic [CLAMP_W-1:0]      clamp_set,
    input  logic                    avg4_en,
    output logic signed [OFS_W-1:0] ofs_word,
    output logic                    settled
);
    logic              srst;
    logic              win, le_evt;
    logic              line_valid, det_valid;
    logic [DATA_W-1:0] line_avg, det_level;

    assign srst = ~soft_rst_n;

    ob_strobe_cond u_strobe (
        .clk(clk), .rst_n(rst_n), .srst(srst), .pol(strobe_pol),
        .win_raw(ob_win_in), .le_raw(line_end_in),
        .win(win), .le_evt(le_evt)
    );

    ob_line_accum #(.DATA_W(DATA_W), .SMP_LOG2(SMP_LOG2)) u_accum (
        .clk(clk), .rst_n(rst_n), .srst(srst), .win(win), .le_evt(le_evt),
        .code(adc_code), .line_valid(line_valid), .line_avg(line_avg)
    );

    ob_avg4 #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_avg (
        .clk(clk), .rst_n(rst_n), .srst(srst), .avg4_en(avg4_en),
        .line_valid(line_valid), .line_avg(line_avg),
        .det_valid(det_valid), .det_level(det_level)
    );

    ob_offset_ctrl #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SETTLE_N(SETTLE_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst(srst), .det_valid(det_valid),
        .det_level(det_level), .clamp_set(clamp_set),
        .ofs(ofs_word), .settled(settled)
    );
endmodule

// File: tb/ob_clamp_loop_tb.sv
`timescale 1ns/1ps
module ob_clamp_loop_tb_top;
    localparam int DATA_W = 10;
    localparam int OFS_W  = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    soft_rst_n = 1'b1;
    logic                    strobe_pol = 1'b1;
    logic                    ob_win_in = 1'b0;
    logic                    line_end_in = 1'b0;
    logic [DATA_W-1:0]       adc_code = '0;
    logic [4:0]              clamp_set = 5'd9;
    logic                    avg4_en = 1'b0;
    logic signed [OFS_W-1:0] ofs_word;
    logic                    settled;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int exp_ofs  = 0;
    int exp_sc   = 0;
    int hist[4];
    int hist_n   = 0;

    always #10 clk = ~clk;

    ob_clamp_loop dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .strobe_pol(strobe_pol), .ob_win_in(ob_win_in),
        .line_end_in(line_end_in), .adc_code(adc_code),
        .clamp_set(clamp_set), .avg4_en(avg4_en),
        .ofs_word(ofs_word), .settled(settled)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(int'(ofs_word) == exp_ofs, {req, " ofs"}, int'(ofs_word), exp_ofs);
        check(settled == (exp_sc >= 4), {req, " settled"}, int'(settled), int'(exp_sc >= 4));
    endtask

    function automatic void model_update(input int level);
        int tgt;
        tgt = 2 * int'(clamp_set) + 14;
        if (level > tgt + 1) begin
            exp_sc = 0;
            if (exp_ofs > -32) exp_ofs--;
        end else if (level < tgt - 1) begin
            exp_sc = 0;
            if (exp_ofs < 31) exp_ofs++;
        end else if (exp_sc < 4) begin
            exp_sc++;
        end
    endfunction

    // a qualifying line in the current mode
    function automatic void model_line(input int level);
        if (!avg4_en) begin
            model_update(level);
        end else begin
            hist[hist_n % 4] = level;
            hist_n++;
            if (hist_n % 4 == 0)
                model_update((hist[0] + hist[1] + hist[2] + hist[3]) / 4);
        end
    endfunction

    task automatic drive_strobes(input bit w, input bit le);
        ob_win_in   = strobe_pol ? w : ~w;
        line_end_in = strobe_pol ? le : ~le;
    endtask

    task automatic send_window(input int base, input int n, input bit ramp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive_strobes(1'b1, 1'b0);
            adc_code = DATA_W'(ramp ? base + i : base);
        end
        @(negedge clk);
        drive_strobes(1'b0, 1'b0);
    endtask

    task automatic end_line(input int hold);
        @(negedge clk);
        drive_strobes(1'b0, 1'b1);
        for (int i = 1; i < hold; i++) @(negedge clk);
        @(negedge clk);
        drive_strobes(1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic flat_line(input int code);
        send_window(code, 16, 1'b0);
        end_line(1);
        model_line(code);
    endtask

    task automatic do_soft_reset();
        @(negedge clk);
        soft_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        soft_rst_n = 1'b1;
        exp_ofs = 0;
        exp_sc  = 0;
        hist_n  = 0;
        for (int i = 0; i < 4; i++) hist[i] = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_state("R11 reset");
    endtask

    task automatic t_target_1h();
        do_soft_reset();
        clamp_set = 5'd9;
        flat_line(40);  check_state("R1 R3 R5 above target 32");
        flat_line(20);  check_state("R5 below target 32");
        flat_line(20);  check_state("R5 below target 32 second");
        flat_line(33);  check_state("R5 in band +1");
        flat_line(31);  check_state("R5 in band -1");
        flat_line(34);  check_state("R5 edge +2");
        flat_line(30);  check_state("R5 edge -2");
        clamp_set = 5'd0;
        flat_line(16);  check_state("R1 setting 0 target 14 high");
        flat_line(15);  check_state("R1 setting 0 target 14 in band");
        clamp_set = 5'd9;
    endtask

    task automatic t_window_avg();
        do_soft_reset();
        send_window(25, 16, 1'b1); end_line(1); model_line(32);
        check_state("R2 ramp mean 32");
        send_window(28, 16, 1'b1); end_line(1); model_line(35);
        check_state("R2 ramp mean 35");
        send_window(32, 16, 1'b0); send_window(1000, 4, 1'b0); end_line(1);
        model_line(32);
        check_state("R2 samples past 16 ignored");
        send_window(100, 15, 1'b0); end_line(1);
        check_state("R2 short window no update");
    endtask

    task automatic t_settle();
        do_soft_reset();
        for (int i = 0; i < 3; i++) flat_line(32);
        check_state("R7 three in-band not settled");
        flat_line(33);
        check_state("R7 fourth in-band settled");
        flat_line(32);
        check_state("R7 stays settled");
        flat_line(50);
        check_state("R7 out of band clears");
    endtask

    task automatic t_saturate();
        do_soft_reset();
        for (int i = 0; i < 36; i++) flat_line(0);
        check_state("R6 top limit");
        for (int i = 0; i < 70; i++) flat_line(200);
        check_state("R6 bottom limit");
    endtask

    task automatic t_avg4();
        do_soft_reset();
        avg4_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            flat_line(100);
            check_state("R4 no update before fourth line");
        end
        flat_line(100);
        check_state("R4 update on fourth line");
        flat_line(20); flat_line(20); flat_line(20);
        check_state("R4 hold within group");
        flat_line(68);
        check_state("R4 mean of four lines in band");
        avg4_en = 1'b0;
    endtask

    task automatic t_soft_reset();
        do_soft_reset();
        flat_line(0); flat_line(0); flat_line(0);
        check_state("R8 before soft reset");
        do_soft_reset();
        check_state("R8 after soft reset");
    endtask

    task automatic t_polarity();
        do_soft_reset();
        @(negedge clk);
        strobe_pol = 1'b0;
        drive_strobes(1'b0, 1'b0);
        flat_line(40);
        check_state("R9 active-low strobes high level");
        flat_line(10);
        flat_line(10);
        check_state("R9 active-low strobes low level");
        @(negedge clk);
        strobe_pol = 1'b1;
        drive_strobes(1'b0, 1'b0);
    endtask

    task automatic t_line_edge();
        do_soft_reset();
        send_window(50, 16, 1'b0); end_line(4); model_line(50);
        check_state("R10 held strobe single update");
        send_window(50, 15, 1'b0);
        @(negedge clk);
        drive_strobes(1'b1, 1'b1);
        @(negedge clk);
        drive_strobes(1'b0, 1'b0);
        @(negedge clk);
        check_state("R10 sample on line end discarded");
        flat_line(50);
        check_state("R10 next line counts again");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_target_1h();
        t_window_avg();
        t_settle();
        t_saturate();
        t_avg4();
        t_soft_reset();
        t_polarity();
        t_line_edge();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule